// File: doc/BRIEF.md
# Centralized Barrier Synchronizer with Departure Gating

This unit lets a fixed group of requesters meet at a common synchronization point. Each requester announces that it has reached the point with a single-cycle arrive pulse and then watches its own release output. The unit keeps three pieces of state: an arrival count, a departure count and a pass/stop flag. Arrivals are counted until the whole group is present. When the final member is counted, every waiter is released.

A released waiter keeps its release output high until it answers with a single-cycle leave pulse. Each leave pulse adds one to the departure count. The next episode cannot start until the departure count shows that everyone has left the previous one. Without this gate, a fast requester could lower the flag while slower members had not yet seen it raised.

Arrivals that land in the same cycle are queued and counted one per cycle, lowest index first. Pulses that break the handshake raise a one-cycle error indication and are otherwise dropped.

Top module: `barrier_sync_unit`

## Requirements
- R1: Out of reset, `release_o` is all zero, `pass_o` is 1 and `proto_err_o` is 0. Internally the arrival count is 0 and the departure count equals PARTIES.
- R2: While fewer than PARTIES arrivals of the current episode have been counted, no waiting requester sees its release bit high. In the cycle after the final arrival is counted, every requester of the episode has its release bit high.
- R3: The requester whose arrival completes the count gets its release bit high for exactly one cycle. It needs no leave pulse and is not added to the departure count, because the departure count restarts at 1.
- R4: A counted waiter that is not the final arrival keeps its release bit high from the release cycle until it gives a leave pulse. That leave pulse clears the bit on the next edge and adds one to the departure count.
- R5: A first arrival of a new episode is held pending while the departure count is below PARTIES. It is counted, and `pass_o` drops to 0, on the edge after the departure count reaches PARTIES.
- R6: `pass_o` falls to 0 when the first arrival of an episode is counted. It rises to 1 when the final arrival is counted.
- R7: Pending arrivals are counted one per clock edge, lowest requester index first. With several simultaneous arrivals, an arrival pulse sampled on one edge is counted no earlier than the following edge. The highest-index member of a simultaneous group completing an episode is therefore the final arrival.
- R8: An arrive pulse from a requester that is pending or waiting sets `proto_err_o` high in the next cycle. The pulse changes no count.
- R9: A leave pulse from a requester whose release bit is not held for a waiting requester sets `proto_err_o` high in the next cycle. The pulse changes no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| arrive_i | input | PARTIES | One-cycle arrival pulse per requester |
| leave_i | input | PARTIES | One-cycle leave acknowledgement per requester |
| release_o | output | PARTIES | Per-requester release indication |
| pass_o | output | 1 | Pass (1) / stop (0) flag |
| proto_err_o | output | 1 | One-cycle protocol error indication |

## Verification
The bench first drives the whole group to arrive in one cycle. This shows the serialized counting latency and which member becomes the final arrival, since that member is the only one whose release drops without a leave.

It then re-enters a member while the others still hold their release. Releasing the waiters one at a time shows that the stall ends exactly when the last departure lands.

A further episode mixes a partial group with duplicate arrivals and misplaced leave pulses. A wrongly counted duplicate would finish the episode early, and a wrongly counted leave would overshoot the departure count and hang the following episode.

// File: rtl/barrier_sync_pkg.sv
package barrier_sync_pkg;

  typedef enum logic [1:0] {
    LANE_IDLE = 2'd0,
    LANE_PEND = 2'd1,
    LANE_WAIT = 2'd2
  } lane_state_e;

  // Number of set bits in a vector of up to 16 requesters.
  function automatic int unsigned ones16(input logic [15:0] v);
    int unsigned n;
    n = 0;
    for (int k = 0; k < 16; k++) n += int'(v[k]);
    return n;
  endfunction

  // Does counting one more arrival complete the episode?
  function automatic logic completes(input int unsigned arr_cnt, input int unsigned parties);
    return (arr_cnt + 1) == parties;
  endfunction

  // A first arrival must wait while earlier waiters have not all left.
  function automatic logic entry_blocked(input int unsigned arr_cnt, input int unsigned dep_cnt,
                                         input int unsigned parties);
    return (arr_cnt == 0) && (dep_cnt != parties);
  endfunction

endpackage

// File: rtl/barrier_sync_arb.sv
module barrier_sync_arb #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic taken;

  always_comb begin
    gnt   = '0;
    taken = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (req[k] && !taken) begin
        gnt[k] = 1'b1;
        taken  = 1'b1;
      end
    end
  end

  // R7: at most one arrival counted per cycle, only a requesting one
  always_comb begin
    assert_one_grant_R7: assert ($onehot0(gnt) && ((gnt & ~req) == '0));
  end
endmodule

// File: rtl/barrier_sync_lane.sv
module barrier_sync_lane
  import barrier_sync_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic arrive,
  input  logic leave,
  input  logic gnt,
  input  logic gnt_final,
  input  logic flag,
  output logic pending,
  output logic departing,
  output logic release_o,
  output logic err
);
  lane_state_e st_q;
  logic        done_q;

  assign pending   = (st_q == LANE_PEND);
  assign departing = (st_q == LANE_WAIT) && flag && leave;
  assign release_o = ((st_q == LANE_WAIT) && flag) || done_q;
  assign err       = (arrive && (st_q != LANE_IDLE)) ||
                     (leave && !((st_q == LANE_WAIT) && flag));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= LANE_IDLE;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        LANE_IDLE: if (arrive) st_q <= LANE_PEND;
        LANE_PEND: if (gnt) begin
          st_q   <= gnt_final ? LANE_IDLE : LANE_WAIT;
          done_q <= gnt_final;
        end
        LANE_WAIT: if (departing) st_q <= LANE_IDLE;
        default:   st_q <= LANE_IDLE;
      endcase
    end
  end

  // R4: a released waiter stays released until it leaves
  assert_hold_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == LANE_WAIT) && flag && !leave) |=> release_o);

  // R8: a repeated arrival while waiting leaves the lane waiting
  assert_dup_arrive_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (arrive && (st_q == LANE_WAIT) && !departing) |=> (st_q == LANE_WAIT));

  // R3: the final arrival's release lasts one cycle
  assert_final_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/barrier_sync_core.sv
module barrier_sync_core
  import barrier_sync_pkg::*;
#(
  parameter int PARTIES = 4,
  parameter int CW      = $clog2(PARTIES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [CW-1:0] n_left,
  output logic          admit,
  output logic          take_final,
  output logic          flag,
  output logic [CW-1:0] arr_cnt,
  output logic [CW-1:0] dep_cnt
);
  localparam logic [CW-1:0] FULL = CW'(PARTIES);

  assign admit      = !entry_blocked(int'(arr_cnt), int'(dep_cnt), PARTIES);
  assign take_final = completes(int'(arr_cnt), PARTIES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arr_cnt <= '0;
      dep_cnt <= FULL;
      flag    <= 1'b1;
    end else begin
      dep_cnt <= dep_cnt + n_left;
      if (take) begin
        if (arr_cnt == '0) flag <= 1'b0;
        if (take_final) begin
          arr_cnt <= '0;
          dep_cnt <= CW'(1);
          flag    <= 1'b1;
        end else begin
          arr_cnt <= arr_cnt + CW'(1);
        end
      end
    end
  end

  // R4: departures never exceed the group size
  assert_dep_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dep_cnt <= FULL) && (arr_cnt < FULL));

  // R5: the flag only drops once every previous waiter has left
  assert_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> ($past(dep_cnt) == FULL));

  // R6: raising the flag restarts both counts
  assert_complete_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> ((arr_cnt == '0) && (dep_cnt == CW'(1))));
endmodule

// File: rtl/barrier_sync_unit.sv
module barrier_sync_unit
  import barrier_sync_pkg::*;
#(
  parameter int PARTIES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PARTIES-1:0] arrive_i,
  input  logic [PARTIES-1:0] leave_i,
  output logic [PARTIES-1:0] release_o,
  output logic               pass_o,
  output logic               proto_err_o
);
  localparam int CW = $clog2(PARTIES + 1);

  logic [PARTIES-1:0] pend, dep_v, err_v, gnt;
  logic [CW-1:0]      n_left, arr_cnt, dep_cnt;
  logic               admit, take_final, flag, err_q;

  barrier_sync_arb #(.N(PARTIES)) u_arb (
    .req (pend & {PARTIES{admit}}),
    .gnt (gnt)
  );

  barrier_sync_core #(.PARTIES(PARTIES), .CW(CW)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (|gnt),
    .n_left     (n_left),
    .admit      (admit),
    .take_final (take_final),
    .flag       (flag),
    .arr_cnt    (arr_cnt),
    .dep_cnt    (dep_cnt)
  );

  for (genvar g = 0; g < PARTIES; g++) begin : g_lane
    barrier_sync_lane u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .arrive    (arrive_i[g]),
      .leave     (leave_i[g]),
      .gnt       (gnt[g]),
      .gnt_final (take_final),
      .flag      (flag),
      .pending   (pend[g]),
      .departing (dep_v[g]),
      .release_o (release_o[g]),
      .err       (err_v[g])
    );
  end

  assign n_left = CW'(ones16(16'(dep_v)));

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= |err_v;
  end

  assign pass_o      = flag;
  assign proto_err_o = err_q;

  // R9: departures happen only while the flag reads pass
  assert_leave_on_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (n_left != '0) |-> flag);
endmodule

// File: tb/sim_barrier_sync_unit.sv
`timescale 1ns/1ps
module sim_barrier_sync_unit;
  localparam int P = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [P-1:0] arrive_i, leave_i, release_o;
  logic         pass_o, proto_err_o;
  int           checks = 0;
  int           errors = 0;

  always #2 clk = ~clk;

  barrier_sync_unit #(.PARTIES(P)) u0 (
    .clk(clk), .rst_n(rst_n), .arrive_i(arrive_i), .leave_i(leave_i),
    .release_o(release_o), .pass_o(pass_o), .proto_err_o(proto_err_o)
  );

  task automatic chk(input string tag, input logic [P-1:0] got, input logic [P-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_arrive(input logic [P-1:0] m);
    arrive_i = m;
    @(negedge clk);
    arrive_i = '0;
  endtask

  task automatic pulse_leave(input logic [P-1:0] m);
    leave_i = m;
    @(negedge clk);
    leave_i = '0;
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic t_reset();
    chk("R1 release", release_o, '0);
    chk("R1 pass", P'(pass_o), P'(1));
    chk("R1 err", P'(proto_err_o), '0);
  endtask

  // All arrive together: counted over P edges, index P-1 is the final one.
  task automatic t_group();
    pulse_arrive('1);
    step(P - 1);
    chk("R2 held", release_o, '0);
    chk("R6 pass low", P'(pass_o), '0);
    step(1);
    chk("R2 all released", release_o, '1);
    chk("R6 pass high", P'(pass_o), P'(1));
    step(1);
    chk("R3 R7 final pulse ends", release_o, 4'b0111);
    step(3);
    chk("R4 held until leave", release_o, 4'b0111);
  endtask

  // Requester 3 re-enters while the others still hold release.
  task automatic t_stall();
    pulse_arrive(4'b1000);
    step(4);
    chk("R5 stalled release", release_o, 4'b0111);
    chk("R5 stalled pass", P'(pass_o), P'(1));
    pulse_leave(4'b0001);
    chk("R4 leave clears", release_o, 4'b0110);
    pulse_leave(4'b0010);
    chk("R5 still stalled", P'(pass_o), P'(1));
    pulse_leave(4'b0100);
    chk("R5 last departure", release_o, '0);
    chk("R5 pass before entry", P'(pass_o), P'(1));
    step(1);
    chk("R5 entry accepted", P'(pass_o), '0);
    pulse_arrive(4'b0111);
    step(2);
    chk("R7 serial counting", release_o, '0);
    step(1);
    chk("R7 group released", release_o, '1);
    step(1);
    chk("R7 index 2 was final", release_o, 4'b1011);
    pulse_leave(4'b1011);
    chk("R4 all left", release_o, '0);
  endtask

  task automatic t_protocol();
    pulse_arrive(4'b0001);
    step(1);
    pulse_arrive(4'b0001);
    chk("R8 dup arrive err", P'(proto_err_o), P'(1));
    pulse_leave(4'b0010);
    chk("R9 stray leave err", P'(proto_err_o), P'(1));
    step(1);
    chk("R8 err clears", P'(proto_err_o), '0);
    pulse_arrive(4'b0110);
    step(3);
    chk("R8 dup not counted pass", P'(pass_o), '0);
    chk("R8 dup not counted release", release_o, '0);
    pulse_arrive(4'b1000);
    step(1);
    chk("R2 released", release_o, '1);
    pulse_leave(4'b1000);
    chk("R9 leave by final err", P'(proto_err_o), P'(1));
    chk("R9 release after stray", release_o, 4'b0111);
    pulse_leave(4'b0111);
    chk("R4 cleared", release_o, '0);
    pulse_arrive(4'b0001);
    step(1);
    chk("R9 stray not counted", P'(pass_o), '0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    rst_n = 1'b0;
    arrive_i = '0;
    leave_i = '0;
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_group();
    t_stall();
    t_protocol();
    step(2);
    report();
  end
endmodule